// File: doc/BRIEF.md
# Addressed Serial Multi-Channel Register Loader

This block is the digital control front end of a six-channel digital potentiometer. A host drives a three-wire serial port: a serial clock, an active-low chip select and a serial data line. While chip select is low, every rising serial clock edge shifts one bit into an 11-bit word register. When chip select returns high, the top three bits of the word are decoded as a channel address, and the addressed 8-bit channel register takes the low eight bits.

A serial output lets several blocks be chained on one data line. Each shifted bit reappears on the output exactly eleven shifts later. The output is modelled as the enable of an open-drain pull-down. An asynchronous active-low preset returns every channel to midscale and clears the output bit. An active-low shutdown input raises a status flag and releases the pull-down, while keeping all channel contents.

All port inputs are sampled by a faster system clock through two-flop synchronizers, and edges are detected in that clock domain. The one exception is preset, which acts asynchronously.

Top module: `serial_chan_loader`

## Requirements
- R1: While `rst` is high at a clock edge, every channel reads 0x80, the serial output bit is cleared (so `sdo_pull` is 1) and `shdn_flag` is 0.
- R2: A word bit is taken only on a rising `sclk_in` edge while `csn_in` is low. Serial clock edges while `csn_in` is high neither shift the word nor move the serial output.
- R3: The word is 11 bits, sent most significant first: address bits [10:8], then data bits [7:0]. Only the last 11 bits shifted before `csn_in` rises are used.
- R4: On a rising `csn_in`, address value k (0 to 5) loads the data byte into channel k+1, which appears on `chan_val[8*k +: 8]`.
- R5: Address values 6 and 7 leave every channel unchanged when `csn_in` rises.
- R6: A load changes at most the one addressed channel. All other channels keep their values.
- R7: After the n-th shift since reset, the serial output bit equals the bit that was shifted in at shift n-11, or 0 if n is 11 or less. `sdo_pull` is 1 exactly when that bit is 0 and shutdown is inactive.
- R8: `presetn_in` low sets every channel to 0x80 and clears the serial output bit at once, without waiting for a clock edge. It overrides a load that happens while it is low.
- R9: While `shdnn_in` is low, `shdn_flag` is 1 and `sdo_pull` is 0. Channel values are kept through shutdown, and `sdo_pull` follows the stored output bit again after shutdown ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Serial clock; rising edges shift |
| csn_in | input | 1 | Active-low chip select; rising edge commits the word |
| sdi_in | input | 1 | Serial data in |
| presetn_in | input | 1 | Asynchronous active-low midscale preset |
| shdnn_in | input | 1 | Active-low shutdown |
| chan_val | output | 48 | Six 8-bit channel values; channel k+1 at bits [8k+7:8k] |
| sdo_pull | output | 1 | Open-drain pull-down enable for the serial output (1 = line driven low) |
| shdn_flag | output | 1 | Shutdown indication |

## Verification
The case that matters is preset and a chip-select load landing together. A valid word sits in the word register with chip select low. The bench pulls preset low, then raises chip select so that the synchronized edge reaches the load decoder while preset is still held. After preset is released, all six channels must read 0x80 and the loaded data byte must appear nowhere. A second coincidence sends serial clock edges during a load window with chip select high, and the bench expects them to have no effect on the word that gets reloaded.

// File: rtl/sl_pkg.sv
`timescale 1ns/1ps
package sl_pkg;
  // indices into the synchronized input bus
  typedef enum int unsigned {
    IN_SCLK  = 0,
    IN_CSN   = 1,
    IN_SDI   = 2,
    IN_SHDNN = 3
  } in_idx_e;

  localparam int unsigned NUM_SYNC_IN = 4;

  function automatic logic [31:0] midscale(input int unsigned width);
    midscale = 32'd1 << (width - 1);
  endfunction
endpackage

// File: rtl/sl_edge_sync.sv
`timescale 1ns/1ps
module sl_edge_sync #(
  parameter int unsigned N = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] level,
  output logic [N-1:0] rise
);
  localparam int unsigned DEPTH = STAGES + 1;

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [DEPTH-1:0] st;
    always_ff @(posedge clk) begin
      if (rst) st <= {DEPTH{RST_VAL[g]}};
      else     st <= {st[DEPTH-2:0], din[g]};
    end
    assign level[g] = st[STAGES-1];
    assign rise[g]  = st[STAGES-1] & ~st[STAGES];
  end
endmodule

// File: rtl/sl_shift_core.sv
`timescale 1ns/1ps
module sl_shift_core #(
  parameter int unsigned WORD_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              presetn,
  input  logic              shift_en,
  input  logic              din,
  output logic [WORD_W-1:0] word,
  output logic              out_bit
);
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst)           word_q <= '0;
    else if (shift_en) word_q <= {word_q[WORD_W-2:0], din};
  end

  // the output bit alone is cleared by the asynchronous preset
  always_ff @(posedge clk or negedge presetn) begin
    if (!presetn)      out_bit <= 1'b0;
    else if (rst)      out_bit <= 1'b0;
    else if (shift_en) out_bit <= word_q[WORD_W-1];
  end

  assign word = word_q;
endmodule

// File: rtl/sl_addr_decode.sv
`timescale 1ns/1ps
module sl_addr_decode #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned NCH    = 6
) (
  input  logic              strobe,
  input  logic [ADDR_W-1:0] addr,
  output logic [NCH-1:0]    load
);
  for (genvar g = 0; g < NCH; g++) begin : g_dec
    localparam logic [ADDR_W-1:0] SEL = ADDR_W'(g);
    assign load[g] = strobe && (addr == SEL);
  end
endmodule

// File: rtl/sl_chan_bank.sv
`timescale 1ns/1ps
module sl_chan_bank #(
  parameter int unsigned NCH    = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  presetn,
  input  logic [NCH-1:0]        load,
  input  logic [DATA_W-1:0]     din,
  output logic [NCH*DATA_W-1:0] vals
);
  localparam logic [DATA_W-1:0] MID = DATA_W'(sl_pkg::midscale(DATA_W));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge presetn) begin
      if (!presetn)     q <= MID;
      else if (rst)     q <= MID;
      else if (load[g]) q <= din;
    end
    assign vals[g*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/serial_chan_loader.sv
`timescale 1ns/1ps
module serial_chan_loader #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NCH    = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sclk_in,
  input  logic                  csn_in,
  input  logic                  sdi_in,
  input  logic                  presetn_in,
  input  logic                  shdnn_in,
  output logic [NCH*DATA_W-1:0] chan_val,
  output logic                  sdo_pull,
  output logic                  shdn_flag
);
  import sl_pkg::*;
  localparam int unsigned WORD_W = ADDR_W + DATA_W;
  localparam logic [NUM_SYNC_IN-1:0] SYNC_RST = 4'b1010; // csn, shdnn idle high

  logic [NUM_SYNC_IN-1:0] raw, lvl, rise;
  logic [WORD_W-1:0]      word;
  logic [NCH-1:0]         load;
  logic                   shift_en, cs_rise, out_bit, shdn_q;

  assign raw[IN_SCLK]  = sclk_in;
  assign raw[IN_CSN]   = csn_in;
  assign raw[IN_SDI]   = sdi_in;
  assign raw[IN_SHDNN] = shdnn_in;

  sl_edge_sync #(.N(NUM_SYNC_IN), .STAGES(STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst), .din(raw), .level(lvl), .rise(rise)
  );

  assign shift_en = rise[IN_SCLK] & ~lvl[IN_CSN];
  assign cs_rise  = rise[IN_CSN];

  sl_shift_core #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .presetn(presetn_in), .shift_en(shift_en),
    .din(lvl[IN_SDI]), .word(word), .out_bit(out_bit)
  );

  sl_addr_decode #(.ADDR_W(ADDR_W), .NCH(NCH)) u_dec (
    .strobe(cs_rise), .addr(word[WORD_W-1 -: ADDR_W]), .load(load)
  );

  sl_chan_bank #(.NCH(NCH), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst(rst), .presetn(presetn_in), .load(load),
    .din(word[DATA_W-1:0]), .vals(chan_val)
  );

  always_ff @(posedge clk) begin
    if (rst) shdn_q <= 1'b0;
    else     shdn_q <= ~lvl[IN_SHDNN];
  end

  assign shdn_flag = shdn_q;
  assign sdo_pull  = ~out_bit & ~shdn_q;
endmodule

// File: rtl/serial_chan_loader_chk.sv
`timescale 1ns/1ps
module serial_chan_loader_chk #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NCH    = 6
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  presetn_in,
  input logic                  load_stb,
  input logic [ADDR_W-1:0]     load_addr,
  input logic [NCH*DATA_W-1:0] chan_val,
  input logic                  sdo_pull,
  input logic                  shdn_flag
);
  localparam logic [DATA_W-1:0] MID = DATA_W'(1 << (DATA_W - 1));

  logic [NCH*DATA_W-1:0] prev_val;
  logic                  prev_ok, prev_pre;
  logic [NCH-1:0]        chg, at_mid;

  always_ff @(posedge clk) begin
    prev_val <= chan_val;
    prev_pre <= presetn_in;
    prev_ok  <= ~rst;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_cmp
    assign chg[g]    = prev_val[g*DATA_W +: DATA_W] != chan_val[g*DATA_W +: DATA_W];
    assign at_mid[g] = chan_val[g*DATA_W +: DATA_W] == MID;
  end

  assert_preset_mid_R8: assert property (@(posedge clk) disable iff (rst)
    !presetn_in |-> &at_mid);

  assert_shdn_release_R9: assert property (@(posedge clk) disable iff (rst)
    shdn_flag |-> !sdo_pull);

  assert_bad_addr_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (load_stb && load_addr >= ADDR_W'(NCH) && presetn_in) |=> ($stable(chan_val) || !presetn_in));

  assert_no_stray_change_R2: assert property (@(posedge clk) disable iff (rst)
    (!load_stb && presetn_in) |=> ($stable(chan_val) || !presetn_in));

  assert_one_channel_R6: assert property (@(posedge clk) disable iff (rst)
    (prev_ok && prev_pre && presetn_in) |-> ($countones(chg) <= 1));
endmodule

bind serial_chan_loader serial_chan_loader_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCH(NCH)
) u_chk (
  .clk(clk), .rst(rst), .presetn_in(presetn_in), .load_stb(cs_rise),
  .load_addr(word[ADDR_W+DATA_W-1 -: ADDR_W]), .chan_val(chan_val),
  .sdo_pull(sdo_pull), .shdn_flag(shdn_flag)
);

// File: tb/serial_chan_loader_test.sv
`timescale 1ns/1ps
module serial_chan_loader_test;
  localparam int NCH = 6;
  localparam int DW  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk_in = 1'b0, csn_in = 1'b1, sdi_in = 1'b0;
  logic presetn_in = 1'b1, shdnn_in = 1'b1;
  logic [NCH*DW-1:0] chan_val;
  logic sdo_pull, shdn_flag;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] exp_ch [NCH];
  bit sdo_q [$];
  bit exp_sdo = 1'b0;
  logic [10:0] exp_word = '0;

  always #2 clk = ~clk;

  serial_chan_loader uut (
    .clk(clk), .rst(rst), .sclk_in(sclk_in), .csn_in(csn_in), .sdi_in(sdi_in),
    .presetn_in(presetn_in), .shdnn_in(shdnn_in), .chan_val(chan_val),
    .sdo_pull(sdo_pull), .shdn_flag(shdn_flag)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_chans(input string req);
    for (int i = 0; i < NCH; i++)
      chk(chan_val[i*DW +: DW] == exp_ch[i], req, 32'(chan_val[i*DW +: DW]), 32'(exp_ch[i]));
  endtask

  // one serial clock pulse; with cs low this is a shift (R2, R7)
  task automatic sbit(input bit b, input bit check_sdo);
    sdi_in = b; tick(4);
    sclk_in = 1'b1; tick(4);
    sclk_in = 1'b0;
    if (!csn_in) begin
      sdo_q.push_back(b);
      exp_sdo = sdo_q.pop_front();
      exp_word = {exp_word[9:0], b};
      if (check_sdo)
        chk(sdo_pull == (!exp_sdo && shdnn_in), "R7 sdo delay", 32'(sdo_pull), 32'(!exp_sdo && shdnn_in));
    end
  endtask

  task automatic cs_down(); csn_in = 1'b0; tick(4); endtask

  task automatic cs_up();
    csn_in = 1'b1; tick(6);
    if (presetn_in && exp_word[10:8] < 3'd6) exp_ch[exp_word[10:8]] = exp_word[7:0];
  endtask

  task automatic send_word(input logic [2:0] a, input logic [7:0] d);
    cs_down();
    for (int i = 10; i >= 0; i--) sbit(({a, d} >> i) & 1'b1, 1'b0);
    cs_up();
  endtask

  task automatic t_reset();
    for (int i = 0; i < NCH; i++) exp_ch[i] = 8'h80;
    for (int i = 0; i < 11; i++) sdo_q.push_back(1'b0);
    chk_chans("R1 reset midscale");
    chk(sdo_pull == 1'b1, "R1 sdo cleared", 32'(sdo_pull), 1);
    chk(shdn_flag == 1'b0, "R1 shdn flag", 32'(shdn_flag), 0);
  endtask

  task automatic t_each_addr();
    for (int a = 0; a < NCH; a++) begin
      send_word(3'(a), 8'(8'h11 * (a + 1) + 8'h03));
      chk_chans("R4 R6 address map");
    end
  endtask

  task automatic t_long_word();
    // 14 bits: leading 3 bits fall off (R3)
    cs_down();
    for (int i = 13; i >= 0; i--) sbit((14'b111_010_10100101 >> i) & 1'b1, 1'b0);
    cs_up();
    chk(exp_ch[2] == 8'hA5, "R3 tb model", 32'(exp_ch[2]), 32'hA5);
    chk_chans("R3 last 11 bits");
  endtask

  task automatic t_invalid();
    send_word(3'd6, 8'h5A); chk_chans("R5 addr 6 ignored");
    send_word(3'd7, 8'hC3); chk_chans("R5 addr 7 ignored");
  endtask

  task automatic t_cs_high_clocks();
    send_word(3'd1, 8'h3C);
    // these edges come with cs high and must not shift (R2)
    for (int i = 10; i >= 0; i--) sbit((11'b010_11110000 >> i) & 1'b1, 1'b0);
    cs_down(); cs_up();
    chk_chans("R2 cs-high clocks ignored");
    chk(chan_val[2*DW +: DW] == exp_ch[2], "R2 ch3 untouched", 32'(chan_val[2*DW +: DW]), 32'(exp_ch[2]));
  endtask

  task automatic t_chain();
    logic [21:0] pat = 22'b101_11001010_011_0110_1001;
    cs_down();
    for (int i = 21; i >= 0; i--) sbit((pat >> i) & 1'b1, 1'b1);
    cs_up();
    chk_chans("R7 R3 chained load");
  endtask

  task automatic t_preset_async();
    send_word(3'd4, 8'h17);
    @(negedge clk); #0.5 presetn_in = 1'b0; #0.5;
    for (int i = 0; i < NCH; i++) exp_ch[i] = 8'h80;
    exp_sdo = 1'b0;
    chk_chans("R8 async midscale");
    chk(sdo_pull == 1'b1, "R8 sdo cleared", 32'(sdo_pull), 1);
    tick(3); presetn_in = 1'b1; tick(2);
  endtask

  task automatic t_preset_vs_load();
    send_word(3'd0, 8'h42);
    cs_down();
    for (int i = 10; i >= 0; i--) sbit((11'b011_11011011 >> i) & 1'b1, 1'b0);
    presetn_in = 1'b0; tick(1);
    csn_in = 1'b1; tick(8);
    presetn_in = 1'b1; tick(3);
    for (int i = 0; i < NCH; i++) exp_ch[i] = 8'h80;
    exp_sdo = 1'b0;
    chk_chans("R8 preset beats load");
  endtask

  task automatic t_shutdown();
    send_word(3'd5, 8'hE1);
    shdnn_in = 1'b0; tick(5);
    chk(shdn_flag == 1'b1, "R9 flag set", 32'(shdn_flag), 1);
    chk(sdo_pull == 1'b0, "R9 sdo released", 32'(sdo_pull), 0);
    chk_chans("R9 values held");
    shdnn_in = 1'b1; tick(5);
    chk(shdn_flag == 1'b0, "R9 flag clear", 32'(shdn_flag), 0);
    chk(sdo_pull == !exp_sdo, "R9 sdo resumes", 32'(sdo_pull), 32'(!exp_sdo));
    chk_chans("R9 values after exit");
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    tick(5); rst = 1'b0; tick(2);
    t_reset();
    t_each_addr();
    t_long_word();
    t_invalid();
    t_cs_high_clocks();
    t_chain();
    t_preset_async();
    t_preset_vs_load();
    t_chain();
    t_shutdown();
    summary();
  end
endmodule